// File: doc/BRIEF.md
# Memory-Type-Aware Access Ordering Buffer

This block sits between a processor's load/store port and one downstream bus. Each request brings a two-bit memory-type code, a shareable bit, an execute-never bit and a flag saying whether it is an instruction fetch. Writes to Normal or Device memory are posted into a small first-in first-out write buffer. Every other access either goes straight to the bus or waits, according to how it must be ordered against the writes still in the buffer. Only ordering is handled here: read data returns on a separate path that is outside this block.

Both sides use valid/ready handshakes. On the request side, the requester holds `req_valid` and every request field steady until it sees `req_ready` high at a clock edge. `req_ready` may depend on `bus_ready` in the same cycle, because a pass-through access is accepted at the same edge where the bus takes it. On the bus side, once `bus_valid` is high and `bus_ready` is low, the block keeps the same transaction on the bus until it is taken. An instruction fetch to an execute-never region never reaches the bus: it is consumed at once, and a single-cycle fault pulse follows.

Top module: `mord_order_buf`

## Requirements
- R1: After reset, `bus_valid` and `xn_fault` are low and the write buffer is empty.
- R2: Writes of type 00 (Normal), 01 (Device non-shareable) and 10 (Device shareable) are posted into a 4-entry buffer. While the buffer is full, `req_ready` is low for such a write. Buffered writes leave for the bus in the order they entered.
- R3: Accesses of type 11 (Strongly-ordered) are never buffered. A Strongly-ordered access of either direction is presented to the bus only when the buffer is empty, so every earlier write has drained first.
- R4: A Normal (00) read or non-faulting fetch may pass buffered writes of any type.
- R5: A Device read (01 or 10) waits behind buffered writes that carry the same type code. It passes buffered writes of the other Device code and of Normal type.
- R6: On the bus, an access never appears ahead of an earlier accepted access when the pair is ordered. A pair is ordered when either member is 11, or when both carry the same Device code.
- R7: A fetch (`req_fetch`=1) with `req_xn`=1 is accepted in the same cycle and never reaches the bus. `xn_fault` is high for exactly the one cycle after that acceptance. A data access with `req_xn`=1 is issued normally and raises no fault.
- R8: `bus_share` is 1 for types 11 and 10, follows `req_share` for type 00, and is 0 for type 01. The `req_share` bit is ignored for every type other than 00.
- R9: When `bus_valid` is high and `bus_ready` is low, the next cycle presents the same transaction with `bus_valid` still high. A buffered write that stalls on the bus goes out before any access can pass it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_xn | input | 1 | Execute-never attribute of the region |
| req_mtype | input | 2 | Memory type: 00 Normal, 01 Device non-shareable, 10 Device shareable, 11 Strongly-ordered |
| req_share | input | 1 | Shareable bit (used for Normal only) |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| bus_valid | output | 1 | Bus transaction present |
| bus_ready | input | 1 | Bus takes the transaction at this edge |
| bus_write | output | 1 | Transaction is a write |
| bus_mtype | output | 2 | Memory type of the transaction |
| bus_share | output | 1 | Effective shareability |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Transaction write data |
| xn_fault | output | 1 | One-cycle memory-management fault pulse |

## Verification
The in-line assertions check a set of properties on every cycle: the buffer never overflows or underflows, it never holds a Strongly-ordered entry, and a Strongly-ordered access appears on the bus only while the buffer is empty. They also check that a stalled bus transaction stays put, that a faulting fetch is consumed without a bus transaction, and that each fault pulse follows such a fetch. Three things need the bench's scenarios, because they depend on the sequence across many requests: the relative order on the bus (Normal bypass, same-type Device blocking, cross-type Device passing, draining before a Strongly-ordered write), full-buffer back-pressure, and the shareability output. A random run tags each request with a sequence number in its address. It checks every bus handshake against all older requests that have not yet been issued.

// File: rtl/mord_pkg.sv
package mord_pkg;
  typedef enum logic [1:0] {
    MT_NORMAL  = 2'b00,
    MT_DEV_NSH = 2'b01,
    MT_DEV_SH  = 2'b10,
    MT_STRONG  = 2'b11
  } mtype_e;

  // effective shareability: strongly-ordered is always shareable
  function automatic logic eff_share(logic [1:0] t, logic s);
    case (t)
      2'b00:   eff_share = s;
      2'b01:   eff_share = 1'b0;
      default: eff_share = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mord_wbuf.sv
module mord_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [1:0]        push_type,
  input  logic              push_share,
  input  logic              pop,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [1:0]        head_type,
  output logic              head_share,
  output logic [3:0]        type_seen
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [1:0]        type_q  [DEPTH];
  logic              share_q [DEPTH];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (push && wr_ptr == PW'(e)) begin
        vld_q[e] <= 1'b1;
      end else if (pop && rd_ptr == PW'(e)) begin
        vld_q[e] <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(e)) begin
        addr_q[e]  <= push_addr;
        data_q[e]  <= push_data;
        type_q[e]  <= push_type;
        share_q[e] <= push_share;
      end
    end
  end

  assign head_addr  = addr_q[rd_ptr];
  assign head_data  = data_q[rd_ptr];
  assign head_type  = type_q[rd_ptr];
  assign head_share = share_q[rd_ptr];

  always_comb begin
    type_seen = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i]) type_seen[type_q[i]] = 1'b1;
  end

  // R2: no write enters a full buffer
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R2: nothing leaves an empty buffer
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  // R3: strongly-ordered never posted
  a_r3_so_not_posted: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_type != 2'b11));
  // R2: occupancy bits agree with the count
  a_r2_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt));
endmodule

// File: rtl/mord_issue.sv
module mord_issue
  import mord_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_fetch,
  input  logic       req_xn,
  input  logic [1:0] req_mtype,
  input  logic       buf_empty,
  input  logic       buf_full,
  input  logic [3:0] type_seen,
  input  logic       bus_ready,
  output logic       req_ready,
  output logic       push,
  output logic       pop,
  output logic       pass_sel,
  output logic       bus_valid,
  output logic       xn_hit
);
  logic lock_q;
  logic is_strong, is_dev, conflict, postable;

  assign xn_hit    = req_valid && req_fetch && req_xn;
  assign is_strong = (req_mtype == MT_STRONG);
  assign is_dev    = (req_mtype == MT_DEV_NSH) || (req_mtype == MT_DEV_SH);
  assign conflict  = is_dev && type_seen[req_mtype];
  assign postable  = req_write && !is_strong;

  assign pass_sel  = req_valid && !xn_hit && !postable && !lock_q &&
                     (is_strong ? buf_empty : !conflict);
  assign bus_valid = pass_sel || !buf_empty;
  assign push      = req_valid && !xn_hit && postable && !buf_full;
  assign pop       = !pass_sel && !buf_empty && bus_ready;
  assign req_ready = xn_hit || (postable ? !buf_full : (pass_sel && bus_ready));

  // a stalled buffer head keeps the bus until it is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= !buf_empty && !pass_sel && !bus_ready;
  end

  // R9: a stalled head is not displaced by a bypassing access
  a_r9_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !pass_sel && !bus_ready) |=> (bus_valid && !pass_sel));
  // R5: device read never passes a buffered write of its own code
  a_r5_dev_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_sel && is_dev) |-> !type_seen[req_mtype]);
endmodule

// File: rtl/mord_order_buf.sv
module mord_order_buf
  import mord_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_xn,
  input  logic [1:0]        req_mtype,
  input  logic              req_share,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [1:0]        bus_mtype,
  output logic              bus_share,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xn_fault
);
  logic              push, pop, pass_sel, xn_hit;
  logic              buf_empty, buf_full;
  logic [3:0]        type_seen;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic [1:0]        h_type;
  logic              h_share;
  logic              fault_q;

  mord_wbuf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(req_addr), .push_data(req_wdata),
    .push_type(req_mtype), .push_share(eff_share(req_mtype, req_share)),
    .pop(pop), .empty(buf_empty), .full(buf_full),
    .head_addr(h_addr), .head_data(h_data), .head_type(h_type),
    .head_share(h_share), .type_seen(type_seen)
  );

  mord_issue u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_fetch(req_fetch),
    .req_xn(req_xn), .req_mtype(req_mtype),
    .buf_empty(buf_empty), .buf_full(buf_full), .type_seen(type_seen),
    .bus_ready(bus_ready), .req_ready(req_ready), .push(push), .pop(pop),
    .pass_sel(pass_sel), .bus_valid(bus_valid), .xn_hit(xn_hit)
  );

  always_comb begin
    if (pass_sel) begin
      bus_write = req_write;
      bus_mtype = req_mtype;
      bus_share = eff_share(req_mtype, req_share);
      bus_addr  = req_addr;
      bus_wdata = req_wdata;
    end else begin
      bus_write = 1'b1;
      bus_mtype = h_type;
      bus_share = h_share;
      bus_addr  = h_addr;
      bus_wdata = h_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= xn_hit;
  end
  assign xn_fault = fault_q;

  // R3: strongly-ordered on the bus only with an empty buffer
  a_r3_so_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_mtype == 2'b11) |-> buf_empty);
  // R7: fault pulse follows a faulting fetch
  a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xn_fault |-> $past(req_valid && req_fetch && req_xn));
  // R7: faulting fetch consumed without a bus transaction
  a_r7_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && req_xn) |-> (req_ready && !pass_sel));
  // R9: stalled transaction held on the bus
  a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_mtype)));
  // R8: strongly-ordered always shareable
  a_r8_so_share: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_mtype == 2'b11) |-> bus_share);
endmodule

// File: tb/test_mord_order_buf.sv
module test_mord_order_buf;
  localparam int MAXR = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic        req_xn = 1'b0, req_share = 1'b0;
  logic [1:0]  req_mtype = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        bus_ready = 1'b0;
  logic        req_ready, bus_valid, bus_write, bus_share, xn_fault;
  logic [1:0]  bus_mtype;
  logic [31:0] bus_addr, bus_wdata;

  always #2 clk = ~clk;

  mord_order_buf i_mord_order_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_xn(req_xn),
    .req_mtype(req_mtype), .req_share(req_share), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_mtype(bus_mtype), .bus_share(bus_share),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .xn_fault(xn_fault)
  );

  int nchk = 0, nfail = 0, nreq = 0, log_n = 0, rdy_mode = 0, faults = 0;
  bit done_flag = 0;
  bit          rq_fault [MAXR];
  bit          rq_done  [MAXR];
  bit          rq_write [MAXR];
  bit          rq_share [MAXR];
  logic [1:0]  rq_type  [MAXR];
  logic [31:0] rq_data  [MAXR];
  int          log_seq  [MAXR];
  bit fault_pend = 0, prev_stall = 0, took = 0;
  logic [31:0] prev_addr = '0;

  function automatic bit ordered(logic [1:0] a, logic [1:0] b);
    return (a == 2'b11) || (b == 2'b11) || (a == b && a != 2'b00);
  endfunction

  function automatic bit exp_share(logic [1:0] t, bit s);
    return (t == 2'b00) ? s : (t != 2'b01);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample();
    int s;
    bit bad;
    if (fault_pend || xn_fault) begin
      check(xn_fault == fault_pend, "R7 fault pulse", xn_fault, fault_pend);
      if (xn_fault) faults++;
    end
    fault_pend = req_valid && req_ready && req_fetch && req_xn;
    if (prev_stall)
      check(bus_valid && bus_addr == prev_addr, "R9 stall hold", bus_addr, prev_addr);
    took = req_valid && req_ready;
    if (bus_valid && bus_ready) begin
      s = int'(bus_addr[15:0]);
      if (s >= nreq || rq_fault[s] || rq_done[s]) begin
        check(0, "R6/R7 unexpected bus transaction", s, nreq);
      end else begin
        bad = 0;
        for (int t = 0; t < s; t++)
          if (!rq_fault[t] && !rq_done[t] && ordered(rq_type[t], rq_type[s])) bad = 1;
        check(!bad, "R6 order", s, 0);
        check(bus_write == rq_write[s] && bus_mtype == rq_type[s],
              "R2 bus attributes", {bus_write, bus_mtype}, {rq_write[s], rq_type[s]});
        if (rq_write[s]) check(bus_wdata == rq_data[s], "R2 write data", bus_wdata, rq_data[s]);
        check(bus_share == exp_share(rq_type[s], rq_share[s]), "R8 share",
              bus_share, exp_share(rq_type[s], rq_share[s]));
        rq_done[s] = 1;
        log_seq[log_n] = s;
        log_n++;
      end
    end
    prev_stall = bus_valid && !bus_ready;
    prev_addr  = bus_addr;
  endtask

  task automatic tick();
    case (rdy_mode)
      0: bus_ready = 1'b0;
      1: bus_ready = 1'b1;
      default: bus_ready = ($urandom % 3) != 0;
    endcase
    #1;
    sample();
    @(negedge clk);
  endtask

  task automatic put(bit w, bit f, bit x, logic [1:0] t, bit sh);
    int s = nreq;
    nreq++;
    rq_write[s] = w; rq_type[s] = t; rq_share[s] = sh;
    rq_fault[s] = f && x; rq_done[s] = 0; rq_data[s] = $urandom;
    req_valid = 1; req_write = w; req_fetch = f; req_xn = x;
    req_mtype = t; req_share = sh; req_addr = {16'h0, 16'(s)}; req_wdata = rq_data[s];
    do tick(); while (!took);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_log(int pos, int seq, string tag);
    check(log_seq[pos] == seq, tag, log_seq[pos], seq);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int b, l, f0;
    void'($urandom(32'h5eed_0042));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(!bus_valid, "R1 bus_valid after reset", bus_valid, 0);
    check(!xn_fault, "R1 xn_fault after reset", xn_fault, 0);
    @(negedge clk);

    // R2 + R4: fill buffer, full stall, normal read bypass after head
    rdy_mode = 0; b = nreq; l = log_n;
    for (int i = 0; i < 4; i++) put(1, 0, 0, 2'b01, 0);
    req_valid = 1; req_write = 1; req_fetch = 0; req_xn = 0; req_mtype = 2'b01;
    req_addr = 32'h0000_ffff; #1;
    check(!req_ready, "R2 full buffer stalls write", req_ready, 0);
    req_valid = 0; @(negedge clk);
    rdy_mode = 1;
    put(0, 0, 0, 2'b00, 0);
    idle(5);
    expect_log(l, b, "R2 head first");
    expect_log(l + 1, b + 4, "R4 normal read bypasses");
    expect_log(l + 2, b + 1, "R2 fifo order");
    expect_log(l + 4, b + 3, "R2 fifo order tail");

    // R5: same device code waits, other device code passes
    rdy_mode = 0; b = nreq; l = log_n;
    put(1, 0, 0, 2'b01, 1); put(1, 0, 0, 2'b01, 1);
    rdy_mode = 1; put(0, 0, 0, 2'b01, 1); idle(4);
    expect_log(l + 2, b + 2, "R5 same-code read waits");
    rdy_mode = 0; b = nreq; l = log_n;
    put(1, 0, 0, 2'b01, 0); put(1, 0, 0, 2'b01, 0);
    rdy_mode = 1; put(0, 0, 0, 2'b10, 0); idle(4);
    expect_log(l + 1, b + 2, "R5 other-code read passes");

    // R3 + R8: strongly-ordered write after drain, share forced
    rdy_mode = 0; b = nreq; l = log_n;
    put(1, 0, 0, 2'b00, 1); put(1, 0, 0, 2'b00, 0);
    rdy_mode = 1; put(1, 0, 0, 2'b11, 0); idle(4);
    expect_log(l, b, "R3 drain first");
    expect_log(l + 2, b + 2, "R3 strongly-ordered last");

    // R7: faulting fetch, xn data read, plain fetch
    b = nreq; l = log_n; f0 = faults;
    put(0, 1, 1, 2'b00, 0);
    put(0, 0, 1, 2'b00, 0);
    put(0, 1, 0, 2'b01, 0);
    idle(4);
    check(faults == f0 + 1, "R7 one fault pulse", faults, f0 + 1);
    check(log_n == l + 2, "R7 fetch not on bus", log_n, l + 2);
    expect_log(l, b + 1, "R7 xn data read issued");

    // random mix, R6 checked at each bus handshake
    rdy_mode = 2;
    for (int i = 0; i < 600; i++) begin
      bit f = ($urandom % 7) == 0;
      bit w = f ? 0 : $urandom % 2;
      put(w, f, ($urandom % 5) == 0, 2'($urandom), 1'($urandom));
    end
    rdy_mode = 1;
    idle(20);
    b = 0;
    for (int t = 0; t < nreq; t++) if (!rq_fault[t] && !rq_done[t]) b++;
    check(b == 0, "R6 every accepted access issued", b, 0);
    finish_run();
  end
endmodule